// File: doc/BRIEF.md
# Per-Area Bus Wait-State Controller

This block decides how many bus states each CPU or DMA access lasts. The three upper address bits pick one of eight areas. A set of static mode inputs says what sits in each area: on-chip ROM in area 0, on-chip RAM in area 7, the on-chip peripheral space in area 5, DRAM in area 1 and multiplexed I/O in area 6. An area whose mode bit is clear is treated as plain external memory.

The cycle length is set by four things: the area type, a per-area wait bit, a shared long-wait count of 1 to 4 states, and the access direction. Together they also decide whether the external WAIT input is honoured. While a cycle runs, `busy` is high. `ready` is high in its last state. When a write goes to plain external area 1 with its write-wait bit clear, the configuration is prohibited. In that case `cfg_err` pulses for one state and the access still completes, so the bus never locks up.

A new access is accepted when the block is idle, or in the ready state of the current cycle. When WAIT is honoured, it is sampled in the state before the final base state and again in every wait state it inserts.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While reset is applied, and at the first sampling point after it, `busy`, `ready` and `cfg_err` are low. A reset in the middle of a cycle drops `busy`.
- R2: The area number is `addr[ADDR_W-1:ADDR_W-3]`. With `rom_on` set, area 0 takes exactly 1 state and ignores WAIT. With `ram_on` set, area 7 does the same.
- R3: With `periph_on` set, area 5 takes exactly 3 states and ignores WAIT, in both directions.
- R4: Plain external areas 1, 3, 4, 5 and 7 follow their `wait_en` bit, except for writes to area 1. With the bit at 0, the access takes 1 state and WAIT is ignored. With the bit at 1, it takes 2 states plus one state per high WAIT sample.
- R5: External areas 0, 2 and 6 support long waits, with L = `long_wait` + 1. A read takes 1+L states. WAIT is ignored if `wait_en` is 0, and adds states if it is 1.
- R6: A write to a long-wait area always takes 1+L states plus the WAIT states, whatever the value of `wait_en`.
- R7: With `dram_on` set, area 1 is a DRAM column cycle in either direction. With `wait_en[1]` at 0, it takes 1 state and ignores WAIT. With the bit at 1, it takes 2 states plus the WAIT states.
- R8: With `mio_on` set, area 6 takes 4 states plus the WAIT states in either direction.
- R9: A write to plain external area 1 takes 2 states plus the WAIT states. If `area1_wr_wait` is 0, `cfg_err` is high in the first state of that cycle and in no other state.
- R10: When WAIT is honoured, it is sampled in the state before the final base state and in each inserted state. Each high sample adds exactly one state. `ready` is high only in the final state, and `busy` stays high through the whole cycle.
- R11: A `start` seen in the ready state begins the next cycle in the following state. A `start` seen while busy and not ready is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Access request |
| addr | input | ADDR_W | Access address; the top 3 bits give the area |
| wr | input | 1 | 1 for write, 0 for read |
| wait_en | input | 8 | Per-area wait bit |
| area1_wr_wait | input | 1 | Write-wait bit for plain external area 1 |
| long_wait | input | 2 | Long-wait count minus one |
| rom_on | input | 1 | Area 0 is on-chip ROM |
| periph_on | input | 1 | Area 5 is on-chip peripheral space |
| ram_on | input | 1 | Area 7 is on-chip RAM |
| dram_on | input | 1 | Area 1 is DRAM |
| mio_on | input | 1 | Area 6 is multiplexed I/O |
| ext_wait | input | 1 | External WAIT, active high |
| busy | output | 1 | Cycle in progress |
| ready | output | 1 | Last state of the cycle |
| cfg_err | output | 1 | Prohibited configuration, first state only |

## Verification
Some properties are checked by assertions on every cycle:
- a cycle never ends before `ready`;
- an ignoring cycle never stretches at its sample point;
- an honoured cycle always inserts a state when WAIT is high there;
- the fixed 1-state and 3-state on-chip cycles finish when due;
- `cfg_err` appears only in a cycle's first state.

Other properties only the bench scenarios can show. These are the exact total length for every area type, both wait-bit values, all four long-wait counts and 0 to 3 WAIT samples, plus the ignoring of WAIT held high for a whole cycle. They also include back-to-back acceptance in the ready state and the dropping of a mid-cycle request.

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wait_en,
  input  logic              area1_wr_wait,
  input  logic [1:0]        long_wait,
  input  logic              rom_on,
  input  logic              periph_on,
  input  logic              ram_on,
  input  logic              dram_on,
  input  logic              mio_on,
  input  logic              ext_wait,
  output logic              busy,
  output logic              ready,
  output logic              cfg_err
);

  logic [2:0]       area;
  logic             accept;
  logic [CNT_W-1:0] lw_len;
  logic [CNT_W-1:0] base_c;
  logic             hon_c, err_c;
  logic             is_long, is_plain;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, hon_q, err_q;

  assign area   = addr[ADDR_W-1 -: 3];
  assign accept = start && (!busy_q || ready);
  assign lw_len = CNT_W'(long_wait) + CNT_W'(1);

  always_comb begin
    is_long  = 1'b0;
    is_plain = 1'b0;
    base_c   = CNT_W'(1);
    hon_c    = 1'b0;
    err_c    = 1'b0;
    case (area)
      3'd0: if (!rom_on)    is_long  = 1'b1;
      3'd1: if (dram_on) begin
              base_c = wait_en[1] ? CNT_W'(2) : CNT_W'(1);
              hon_c  = wait_en[1];
            end else        is_plain = 1'b1;
      3'd2:                 is_long  = 1'b1;
      3'd5: if (periph_on)  base_c   = CNT_W'(3);
            else            is_plain = 1'b1;
      3'd6: if (mio_on) begin
              base_c = CNT_W'(4);
              hon_c  = 1'b1;
            end else        is_long  = 1'b1;
      3'd7: if (!ram_on)    is_plain = 1'b1;
      default:              is_plain = 1'b1;
    endcase
    if (is_long) begin
      base_c = CNT_W'(1) + lw_len;
      hon_c  = wr || wait_en[area];
    end
    if (is_plain) begin
      if (wr && area == 3'd1) begin
        base_c = CNT_W'(2);
        hon_c  = 1'b1;
        err_c  = !area1_wr_wait;
      end else begin
        base_c = wait_en[area] ? CNT_W'(2) : CNT_W'(1);
        hon_c  = wait_en[area];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      hon_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && err_c;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= base_c - CNT_W'(1);
        hon_q  <= hon_c;
      end else if (busy_q) begin
        if (cnt_q == '0)
          busy_q <= 1'b0;
        else if (!(cnt_q == CNT_W'(1) && hon_q && ext_wait))
          cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy    = busy_q;
  assign ready   = busy_q && (cnt_q == '0);
  assign cfg_err = err_q;

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ready |=> busy);

  p_wait_insert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_q == CNT_W'(1) && hon_q && ext_wait |=> busy && !ready);

  p_wait_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_q == CNT_W'(1) && !hon_q |=> ready);

  p_onchip_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((area == 3'd0 && rom_on) || (area == 3'd7 && ram_on)) |=> ready);

  p_periph_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && area == 3'd5 && periph_on |=> !ready ##1 !ready ##1 ready);

  p_err_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> busy && $past(accept));

endmodule

// File: tb/bus_wait_ctrl_test.sv
`timescale 1ns/1ps
module bus_wait_ctrl_test;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, area1_wr_wait = 1'b0, ext_wait = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wait_en = '0;
  logic [1:0] long_wait = '0;
  logic rom_on = 1'b0, periph_on = 1'b0, ram_on = 1'b0, dram_on = 1'b0, mio_on = 1'b0;
  logic busy, ready, cfg_err;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_wait_ctrl #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wr(wr),
    .wait_en(wait_en), .area1_wr_wait(area1_wr_wait), .long_wait(long_wait),
    .rom_on(rom_on), .periph_on(periph_on), .ram_on(ram_on), .dram_on(dram_on),
    .mio_on(mio_on), .ext_wait(ext_wait), .busy(busy), .ready(ready), .cfg_err(cfg_err));

  // {area, wr, bit, lw, mode{mio,dram,ram,periph,rom}, base, honour, err}
  localparam int NV = 24;
  localparam logic [17:0] TBL [NV] = '{
    {3'd0,1'b0,1'b0,2'd0,5'b00001,4'd1,1'b0,1'b0},  // R2 rom
    {3'd7,1'b1,1'b1,2'd0,5'b00100,4'd1,1'b0,1'b0},  // R2 ram
    {3'd5,1'b0,1'b1,2'd0,5'b00010,4'd3,1'b0,1'b0},  // R3
    {3'd5,1'b1,1'b0,2'd0,5'b00010,4'd3,1'b0,1'b0},  // R3
    {3'd3,1'b0,1'b0,2'd0,5'b00000,4'd1,1'b0,1'b0},  // R4
    {3'd3,1'b0,1'b1,2'd0,5'b00000,4'd2,1'b1,1'b0},  // R4
    {3'd4,1'b1,1'b0,2'd0,5'b00000,4'd1,1'b0,1'b0},  // R4
    {3'd7,1'b1,1'b1,2'd0,5'b00000,4'd2,1'b1,1'b0},  // R4
    {3'd1,1'b0,1'b0,2'd0,5'b00000,4'd1,1'b0,1'b0},  // R4
    {3'd1,1'b0,1'b1,2'd0,5'b00000,4'd2,1'b1,1'b0},  // R4
    {3'd1,1'b1,1'b0,2'd0,5'b00000,4'd2,1'b1,1'b1},  // R9 prohibited
    {3'd1,1'b1,1'b1,2'd0,5'b00000,4'd2,1'b1,1'b0},  // R9
    {3'd1,1'b0,1'b0,2'd0,5'b01000,4'd1,1'b0,1'b0},  // R7 short pitch
    {3'd1,1'b1,1'b1,2'd0,5'b01000,4'd2,1'b1,1'b0},  // R7 long pitch
    {3'd6,1'b0,1'b0,2'd0,5'b10000,4'd4,1'b1,1'b0},  // R8
    {3'd6,1'b1,1'b1,2'd0,5'b10000,4'd4,1'b1,1'b0},  // R8
    {3'd0,1'b0,1'b0,2'd0,5'b00000,4'd2,1'b0,1'b0},  // R5
    {3'd2,1'b0,1'b0,2'd3,5'b00000,4'd5,1'b0,1'b0},  // R5
    {3'd2,1'b0,1'b1,2'd1,5'b00000,4'd3,1'b1,1'b0},  // R5
    {3'd6,1'b0,1'b1,2'd2,5'b00000,4'd4,1'b1,1'b0},  // R5
    {3'd0,1'b1,1'b0,2'd0,5'b00000,4'd2,1'b1,1'b0},  // R6
    {3'd6,1'b1,1'b0,2'd3,5'b00000,4'd5,1'b1,1'b0},  // R6
    {3'd2,1'b1,1'b1,2'd2,5'b00000,4'd4,1'b1,1'b0},  // R6
    {3'd5,1'b0,1'b1,2'd0,5'b00001,4'd2,1'b1,1'b0}   // R4 area 5 external
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] ar, input logic w, input logic b,
                         input logic [1:0] lw, input logic [4:0] md);
    addr = {ar, 21'h0_1234};
    wr = w;
    wait_en = {8{b}};
    area1_wr_wait = b;
    long_wait = lw;
    {mio_on, dram_on, ram_on, periph_on, rom_on} = md;
  endtask

  task automatic do_access(input int hold, output int len, output logic e1, output logic elate);
    start = 1'b1;
    ext_wait = 1'b0;
    len = 0; e1 = 1'b0; elate = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (n == 1) e1 = cfg_err;
      else if (cfg_err) elate = 1'b1;
      ext_wait = (n <= hold);
      if (ready) begin
        len = n;
        break;
      end
    end
    ext_wait = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int len, base, exp, hold;
    logic e1, elate;
    repeat (3) @(negedge clk);
    check(!busy && !ready && !cfg_err, "R1 reset", {busy, ready, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !ready && !cfg_err, "R1 after reset", {busy, ready, cfg_err}, 0);

    for (int i = 0; i < NV; i++) begin
      for (int w = 0; w < 4; w++) begin
        set_cfg(TBL[i][17:15], TBL[i][14], TBL[i][13], TBL[i][12:11], TBL[i][10:6]);
        base = int'(TBL[i][5:2]);
        exp  = TBL[i][1] ? base + w : base;
        hold = TBL[i][1] ? base - 2 + w : 30;
        do_access(hold, len, e1, elate);
        check(len == exp, $sformatf("R10 cycle length vec %0d w %0d", i, w), len, exp);
        check(e1 == TBL[i][0] && !elate, $sformatf("R9 cfg_err vec %0d", i),
              {e1, elate}, {TBL[i][0], 1'b0});
      end
    end

    // R11: request mid-cycle ignored, request in ready state accepted
    set_cfg(3'd5, 1'b0, 1'b0, 2'd0, 5'b00011);
    start = 1'b1;
    @(negedge clk);
    check(busy && !ready, "R11 periph state 1", {busy, ready}, 2);
    set_cfg(3'd3, 1'b0, 1'b0, 2'd0, 5'b00011);
    @(negedge clk);
    start = 1'b0;
    check(busy && !ready, "R11 mid request ignored", {busy, ready}, 2);
    @(negedge clk);
    check(busy && ready, "R3 periph ready state 3", {busy, ready}, 3);
    set_cfg(3'd0, 1'b0, 1'b0, 2'd0, 5'b00011);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && ready, "R11 back-to-back rom cycle", {busy, ready}, 3);
    @(negedge clk);
    check(!busy && !ready, "R11 no extra cycle", {busy, ready}, 0);

    // R1: reset mid-cycle
    set_cfg(3'd6, 1'b0, 1'b0, 2'd0, 5'b10000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    check(!busy && !ready && !cfg_err, "R1 reset mid-cycle", {busy, ready, cfg_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1 idle after mid reset", busy, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule